// File: doc/BRIEF.md
# Redundant check event filter

This block sits between an event capture stage and the software handlers that check memory accesses. Each incoming event has a kind and an address. Check events are loads and stores. Other events, such as a free of an allocation, a lock or unlock, or anything else, are not checks. A check whose result would match an earlier check is dropped, because the address and the checked metadata have not changed since then. Every other event is forwarded one cycle later with its kind and address unchanged.

The filter is a small set-associative tag store. Addresses are tracked per 4-byte word. Each way keeps a valid bit, a tag, and two bits that record whether a load or a store to that word has already been delivered. A parameter selects one of two monitoring modes:

- **Allocation mode.** Any earlier check of a word covers later loads and stores to it. A free event empties the filter.
- **Race mode.** Loads and stores are tracked separately. A lock or unlock event empties the filter.

When a set is full, a per-set tree pseudo-LRU picks the way to replace.

Top module: `chk_filter`

## Requirements
- R1: After reset, out_valid is 0 and every check event is treated as never seen.
- R2: An event that is not dropped appears on the outputs exactly one cycle after it is presented, with the same kind and address. In any cycle after a cycle with ev_valid low, out_valid is 0. Kind codes are: 0 other, 1 load, 2 store, 3 free, 4 sync (lock or unlock).
- R3: Kind 0, kinds 5 to 7, and whichever of free or sync is not the invalidating kind for the current mode are always forwarded. They leave the filter contents unchanged.
- R4: The first load or store check to a word after reset or after an invalidation is delivered.
- R5: In race mode (MODE=1), a load is dropped if a load to the same word was already delivered, and a store is dropped if a store was already delivered. A check of the other kind is still delivered once.
- R6: In allocation mode (MODE=0), after either check kind to a word is delivered, later loads and stores to that word are dropped.
- R7: Address bits [1:0] are ignored. Addresses within one 4-byte word share an entry, and different words never share one.
- R8: The invalidating event (free in allocation mode, sync in race mode) is forwarded. It clears every entry in one cycle, so the next check to any word is delivered.
- R9: The filter holds 64 words at once: 16 sets selected by address bits [5:2], with 4 ways each. After 64 distinct words are checked, repeats of all of them are dropped.
- R10: Four distinct tags checked in order into an empty set fill it. A fifth tag replaces the least recently touched of the four, and the other three stay held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_addr | input | ADDR_W | Event address |
| out_valid | output | 1 | Forwarded event present |
| out_kind | output | 3 | Forwarded event kind |
| out_addr | output | ADDR_W | Forwarded event address |

## Verification
The hardest case to reach from the ports is replacement in a full set. Reaching it needs four distinct tags that share one set, checked from an empty filter, followed by a fifth. The stimulus first sends both invalidating kinds to empty the filter. It then checks five word addresses spaced 64 bytes apart, which all land in set 0. Finally it probes each of the five: only the oldest should be delivered again. A full sweep over all 64 word addresses, with loads and then stores, covers capacity and the load/store split in both modes at once.

// File: rtl/chk_filter_pkg.sv
package chk_filter_pkg;
   localparam logic [2:0] KIND_OTHER = 3'd0;
   localparam logic [2:0] KIND_LOAD  = 3'd1;
   localparam logic [2:0] KIND_STORE = 3'd2;
   localparam logic [2:0] KIND_FREE  = 3'd3;
   localparam logic [2:0] KIND_SYNC  = 3'd4;

   localparam int MODE_ALLOC = 0;
   localparam int MODE_RACE  = 1;

   typedef struct packed {
      logic ld;
      logic st;
   } seen_t;
endpackage

// File: rtl/chk_filter_lookup.sv
module chk_filter_lookup
   import chk_filter_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int TAG_W = 26
) (
   input  logic [WAYS-1:0]             row_vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
   input  seen_t [WAYS-1:0]            row_seen,
   input  logic [TAG_W-1:0]            req_tag,
   output logic                        hit,
   output logic [$clog2(WAYS)-1:0]     hit_way,
   output seen_t                       hit_seen,
   output logic                        has_free,
   output logic [$clog2(WAYS)-1:0]     free_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = row_vld[w] && (row_tag[w] == req_tag);
   end

   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w])    hit_way  = WAY_W'(w);
         if (!row_vld[w]) free_way = WAY_W'(w);
      end
   end

   assign hit      = |match;
   assign has_free = ~&row_vld;
   assign hit_seen = row_seen[hit_way];
endmodule

// File: rtl/chk_filter_plru.sv
module chk_filter_plru #(
   parameter int SETS = 16,
   parameter int WAYS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      touch_en,
   input  logic [$clog2(SETS)-1:0]   set_idx,
   input  logic [$clog2(WAYS)-1:0]   touch_way,
   output logic [$clog2(WAYS)-1:0]   victim
);
   localparam int NODES = WAYS - 1;
   localparam int LVL   = $clog2(WAYS);
   localparam int WAY_W = $clog2(WAYS);

   logic [NODES-1:0] tree_q [SETS];
   logic [NODES-1:0] cur, nxt;

   assign cur = tree_q[set_idx];

   always_comb begin
      int node;
      node = 0;
      for (int l = 0; l < LVL; l++) begin
         node = 2 * node + 1 + int'(cur[node]);
      end
      victim = WAY_W'(node - NODES);
   end

   always_comb begin
      int node;
      nxt  = cur;
      node = 0;
      for (int l = 0; l < LVL; l++) begin
         nxt[node] = ~touch_way[LVL-1-l];
         node      = 2 * node + 1 + int'(touch_way[LVL-1-l]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_en) begin
         tree_q[set_idx] <= nxt;
      end
   end
endmodule

// File: rtl/chk_filter.sv
module chk_filter
   import chk_filter_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SETS      = 16,
   parameter int WAYS      = 4,
   parameter int GRAN_BITS = 2,
   parameter int MODE      = MODE_ALLOC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [2:0]        ev_kind,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic              out_valid,
   output logic [2:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - SET_W - GRAN_BITS;
   localparam logic [2:0] INV_CODE = (MODE == MODE_ALLOC) ? KIND_FREE : KIND_SYNC;

   if ((SETS & (SETS - 1)) != 0 || SETS < 1) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS * WAYS < 8 || SETS * WAYS > 256) begin : g_bad_size
      $error("filter size must lie in 8..256 entries");
   end
   if (MODE != MODE_ALLOC && MODE != MODE_RACE) begin : g_bad_mode
      $error("MODE must be 0 or 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the set index");
   end

   logic                 is_ld, is_st, is_chk, is_inv;
   logic [SET_W-1:0]     set_idx;
   logic [TAG_W-1:0]     req_tag;

   assign is_ld   = ev_valid && (ev_kind == KIND_LOAD);
   assign is_st   = ev_valid && (ev_kind == KIND_STORE);
   assign is_chk  = is_ld || is_st;
   assign is_inv  = ev_valid && (ev_kind == INV_CODE);
   assign set_idx = ev_addr[GRAN_BITS +: SET_W];
   assign req_tag = ev_addr[ADDR_W-1 -: TAG_W];

   logic [SETS-1:0][WAYS-1:0] vld_q;
   logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
   seen_t                     seen_q [SETS][WAYS];

   logic [WAYS-1:0][TAG_W-1:0] row_tag;
   seen_t [WAYS-1:0]           row_seen;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         row_tag[w]  = tag_q[set_idx][w];
         row_seen[w] = seen_q[set_idx][w];
      end
   end

   logic             hit, has_free;
   logic [WAY_W-1:0] hit_way, free_way, victim, fill_way;
   seen_t            hit_seen, new_seen;
   logic             drop_hit;

   chk_filter_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lookup (
      .row_vld  (vld_q[set_idx]),
      .row_tag  (row_tag),
      .row_seen (row_seen),
      .req_tag  (req_tag),
      .hit      (hit),
      .hit_way  (hit_way),
      .hit_seen (hit_seen),
      .has_free (has_free),
      .free_way (free_way)
   );

   chk_filter_plru #(.SETS(SETS), .WAYS(WAYS)) i_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (is_chk),
      .set_idx   (set_idx),
      .touch_way (fill_way),
      .victim    (victim)
   );

   if (MODE == MODE_ALLOC) begin : g_alloc
      assign drop_hit = hit && (hit_seen.ld || hit_seen.st);
   end else begin : g_race
      assign drop_hit = hit && (is_ld ? hit_seen.ld : hit_seen.st);
   end

   assign fill_way    = hit ? hit_way : (has_free ? free_way : victim);
   assign new_seen.ld = is_ld || (hit && hit_seen.ld);
   assign new_seen.st = is_st || (hit && hit_seen.st);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (is_inv) begin
         vld_q <= '0;
      end else if (is_chk) begin
         vld_q[set_idx][fill_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (is_chk) begin
         tag_q[set_idx][fill_way]  <= req_tag;
         seen_q[set_idx][fill_way] <= new_seen;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_kind  <= KIND_OTHER;
         out_addr  <= '0;
      end else begin
         out_valid <= ev_valid && !(is_chk && drop_hit);
         out_kind  <= ev_kind;
         out_addr  <= ev_addr;
      end
   end
endmodule

// File: rtl/chk_filter_chk.sv
module chk_filter_chk
   import chk_filter_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 2,
   parameter int MODE      = MODE_ALLOC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic [2:0]        ev_kind,
   input logic [ADDR_W-1:0] ev_addr,
   input logic              out_valid,
   input logic [2:0]        out_kind,
   input logic [ADDR_W-1:0] out_addr
);
   localparam logic [2:0] INV_CODE = (MODE == MODE_ALLOC) ? KIND_FREE : KIND_SYNC;

   logic armed;
   logic ev_chk;

   assign ev_chk = ev_valid && (ev_kind == KIND_LOAD || ev_kind == KIND_STORE);

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !out_valid);

   // R3
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_chk) |=>
         (out_valid && out_kind == $past(ev_kind) && out_addr == $past(ev_addr)));

   // R5
   repeat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ev_valid && ev_kind == KIND_LOAD && $past(ev_valid)
       && $past(ev_kind) == KIND_LOAD
       && $past(ev_addr[ADDR_W-1:GRAN_BITS]) == ev_addr[ADDR_W-1:GRAN_BITS])
      |=> !out_valid);

   // R8
   inv_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ev_chk && $past(ev_valid) && $past(ev_kind) == INV_CODE)
      |=> out_valid);
endmodule

bind chk_filter chk_filter_chk #(
   .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .MODE(MODE)
) i_chk_filter_chk (.*);

// File: tb/test_chk_filter.sv
module test_chk_filter;
   localparam logic [2:0] K_OTHER = 3'd0;
   localparam logic [2:0] K_LOAD  = 3'd1;
   localparam logic [2:0] K_STORE = 3'd2;
   localparam logic [2:0] K_FREE  = 3'd3;
   localparam logic [2:0] K_SYNC  = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [2:0]  ev_kind = 3'd0;
   logic [31:0] ev_addr = '0;
   logic        va, vr;
   logic [2:0]  ka, kr;
   logic [31:0] aa, ar;
   int          checks = 0;
   int          errors = 0;
   logic        done = 1'b0;

   always #5 clk = ~clk;

   chk_filter #(.MODE(0)) i_chk_filter (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_addr(ev_addr), .out_valid(va), .out_kind(ka), .out_addr(aa));

   chk_filter #(.MODE(1)) i_chk_filter_race (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_addr(ev_addr), .out_valid(vr), .out_kind(kr), .out_addr(ar));

   task automatic judge(input logic v, input logic [2:0] k, input logic [31:0] a,
                        input logic ev, input logic [2:0] ek, input logic [31:0] ea,
                        input string req, input string who);
      checks++;
      if (v !== ev || (ev && (k !== ek || a !== ea))) begin
         errors++;
         $display("FAIL %s %s: valid=%0b kind=%0d addr=%h expected valid=%0b kind=%0d addr=%h",
                  req, who, v, k, a, ev, ek, ea);
      end
   endtask

   task automatic send(input logic [2:0] k, input logic [31:0] a,
                       input logic exp_a, input logic exp_r, input string req);
      ev_valid = 1'b1;
      ev_kind  = k;
      ev_addr  = a;
      @(negedge clk);
      ev_valid = 1'b0;
      judge(va, ka, aa, exp_a, k, a, req, "alloc");
      judge(vr, kr, ar, exp_r, k, a, req, "race");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle in reset
      judge(va, ka, aa, 1'b0, K_OTHER, '0, "R1", "alloc");
      judge(vr, kr, ar, 1'b0, K_OTHER, '0, "R1", "race");
      rst_n = 1'b1;
      @(negedge clk);
      // R2: no event, no output
      judge(va, ka, aa, 1'b0, K_OTHER, '0, "R2", "alloc");
      judge(vr, kr, ar, 1'b0, K_OTHER, '0, "R2", "race");

      // R4 / R9: first loads to 64 words all delivered
      for (int w = 0; w < 64; w++) send(K_LOAD, 32'(w * 4), 1'b1, 1'b1, "R4");
      // R9: repeat loads all dropped
      for (int w = 0; w < 64; w++) send(K_LOAD, 32'(w * 4), 1'b0, 1'b0, "R9");
      // R5 / R6: first stores: alloc drops, race delivers once
      for (int w = 0; w < 64; w++) send(K_STORE, 32'(w * 4), 1'b0, 1'b1, "R6");
      for (int w = 0; w < 64; w++) send(K_STORE, 32'(w * 4), 1'b0, 1'b0, "R5");
      // R7: byte offset within a seen word shares the entry
      for (int w = 0; w < 64; w++) send(K_LOAD, 32'(w * 4 + 3), 1'b0, 1'b0, "R7");

      // R3: pass-through kinds, no effect on contents
      send(K_OTHER, 32'h0000_0010, 1'b1, 1'b1, "R3");
      send(3'd5, 32'h1234_5678, 1'b1, 1'b1, "R3");
      send(3'd6, 32'h0000_0004, 1'b1, 1'b1, "R3");
      send(3'd7, 32'hffff_fffc, 1'b1, 1'b1, "R3");
      send(K_LOAD, 32'h0000_0010, 1'b0, 1'b0, "R3");
      // R8 alloc / R3 race: free
      send(K_FREE, 32'h0000_0000, 1'b1, 1'b1, "R8");
      send(K_LOAD, 32'h0000_0000, 1'b1, 1'b0, "R8");
      send(K_STORE, 32'h0000_0004, 1'b1, 1'b0, "R8");
      // R8 race / R3 alloc: sync
      send(K_SYNC, 32'h0000_0000, 1'b1, 1'b1, "R8");
      send(K_LOAD, 32'h0000_0000, 1'b0, 1'b1, "R8");
      send(K_STORE, 32'h0000_0008, 1'b1, 1'b1, "R3");

      // Empty both filters
      send(K_FREE, 32'h0, 1'b1, 1'b1, "R8");
      send(K_SYNC, 32'h0, 1'b1, 1'b1, "R8");
      // R5: store first then load in a word of set 1
      send(K_STORE, 32'h0000_0404, 1'b1, 1'b1, "R5");
      send(K_LOAD, 32'h0000_0404, 1'b0, 1'b1, "R5");
      send(K_LOAD, 32'h0000_0405, 1'b0, 1'b0, "R5");

      // R10: five tags into set 0
      for (int k = 0; k < 5; k++) send(K_LOAD, 32'(k * 64), 1'b1, 1'b1, "R10");
      for (int k = 1; k < 5; k++) send(K_LOAD, 32'(k * 64), 1'b0, 1'b0, "R10");
      send(K_LOAD, 32'h0, 1'b1, 1'b1, "R10");

      // R2: idle again
      @(negedge clk);
      judge(va, ka, aa, 1'b0, K_OTHER, '0, "R2", "alloc");
      judge(vr, kr, ar, 1'b0, K_OTHER, '0, "R2", "race");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: valid=x expected run end");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule